// File: doc/BRIEF.md
# Per-Channel Configuration Latch Bank

This block is a small addressed register file that holds configuration for a two-channel serial link. A host writes one byte at a time through a 3-bit address, an 8-bit data bus and a write strobe. The eight addresses are split as follows:

- Addresses 0 to 2 belong to channel A and addresses 3 to 5 belong to channel B.
- Within each channel, the first two addresses are static latches and the third is the dynamic latch.
- Addresses 6 and 7 are protected test locations.

The latched bytes are presented as a raw view. A handful of fields are also decoded into named control outputs: receive mode, PLL power-down, output enables, transmit BIST enable and phase-alignment-buffer reset.

A channel's static latches are meant to be loaded once after reset, before any dynamic setting is made. For each channel, the first write to its dynamic latch seals that channel's static latches. Every later write to those static latches is dropped. The dynamic latch stays writable at all times. Writes to the protected test locations change nothing, and the block flags them with a one-cycle error pulse. An active-low reset returns both channels to their reset values and unseals both channels.

Top module: `cfgl_bank`

## Requirements
- R1: While reset is asserted and right after it is released:
  - Every static location reads 0x00 and each dynamic location (address 2 and address 5) reads 0x04.
  - `wr_err` is 0 and both `static_locked` bits are 0.
  - `cfg_words` holds location i in bits [8i+7:8i].
- R2: A write is taken at a rising clock edge only while `wr_en` is high. The new value appears on `cfg_words` and on the decoded outputs from that edge onward. While `wr_en` is low, nothing changes.
- R3: The dynamic locations (address 2 for channel A, address 5 for channel B) accept every write, whether or not the channel is sealed.
- R4: A static location (addresses 0, 1, 3 and 4) accepts writes only until its channel's dynamic location has been written once after reset. Later writes to it leave its value unchanged. `static_locked[c]` goes high at the edge of that first dynamic write and stays high until the next reset.
- R5: Sealing is per channel. `static_locked[0]` belongs to channel A and `static_locked[1]` to channel B. A dynamic write on one channel leaves the other channel's static locations writable.
- R6: A write to address 6 or 7 changes no location. `wr_err` is high for exactly the one cycle after that write edge. `wr_err` is low in every other cycle.
- R7: Bits [1:0] of location 2 select channel A's receive mode:
  - 01 drives `a_rx_video_en` high.
  - 10 drives `a_rx_bist_en` high.
  - 00 and 11 drive both low.
- R8: The remaining decoded outputs map to latched bits as follows:
  - `a_rx_pll_pd` is location 2 bit 2.
  - `a_rx_oe` is location 0 bits [1:0].
  - `b_tx_oe` is location 3 bits [1:0].
  - `b_pab_rst` is location 5 bit 0.
  - `b_tx_bist_en` is location 5 bit 1.
- R9: Asserting reset in the middle of operation restores the R1 values on both channels and clears both seals, so static writes are accepted again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes are taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write strobe |
| wr_addr | input | 3 | Location address |
| wr_data | input | 8 | Write data |
| cfg_words | output | 48 | Raw view of locations 0 to 5, location i in bits [8i+7:8i] |
| a_rx_video_en | output | 1 | Channel A receive mode is video data |
| a_rx_bist_en | output | 1 | Channel A receive mode is BIST data |
| a_rx_pll_pd | output | 1 | Channel A receive PLL power-down |
| a_rx_oe | output | 2 | Channel A receive output enables |
| b_tx_oe | output | 2 | Channel B transmit output enables |
| b_tx_bist_en | output | 1 | Channel B transmit BIST enable |
| b_pab_rst | output | 1 | Channel B phase-alignment-buffer reset |
| static_locked | output | 2 | Per-channel static seal, bit 0 for channel A |
| wr_err | output | 1 | One-cycle pulse after a write to a protected address |

## Verification
The bench sweeps all eight addresses with several data bytes in three seal states:

- Both channels open.
- Only channel B sealed.
- Both channels sealed.

Comparing these states separates per-channel sealing from a global seal, and separates the static class from the dynamic class. It also confirms that the protected addresses leave every location untouched in each state. Channel A's mode field is driven through all four codes so that the video and BIST decodes are distinguished from the two inert codes. A strobe-low cycle with live address and data, plus a mid-run reset followed by a static rewrite, show that the strobe gates writes and that reset unseals both channels.

// File: rtl/cfgl_pkg.sv
package cfgl_pkg;

  typedef enum logic [1:0] {
    LOC_STATIC  = 2'd0,
    LOC_DYNAMIC = 2'd1,
    LOC_TEST    = 2'd2
  } loc_kind_e;

  localparam logic [1:0] RXM_VIDEO = 2'b01;
  localparam logic [1:0] RXM_BIST  = 2'b10;

  // Class of a location: the last slot of each channel group is dynamic,
  // anything past the used range is a protected test location.
  function automatic loc_kind_e kind_of(int unsigned a, int unsigned per_ch,
                                        int unsigned used);
    if (a >= used) return LOC_TEST;
    if ((a % per_ch) == per_ch - 1) return LOC_DYNAMIC;
    return LOC_STATIC;
  endfunction

  function automatic int unsigned chan_of(int unsigned a, int unsigned per_ch);
    return a / per_ch;
  endfunction

  // Reset byte: dynamic locations come up with the PLL power-down bit set.
  function automatic logic [7:0] reset_of(loc_kind_e k);
    return (k == LOC_DYNAMIC) ? 8'h04 : 8'h00;
  endfunction

endpackage

// File: rtl/cfgl_decode.sv
module cfgl_decode #(
  parameter int ADDR_W      = 3,
  parameter int NUM_CH      = 2,
  parameter int LOCS_PER_CH = 3,
  localparam int NUM_USED   = NUM_CH * LOCS_PER_CH
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  output logic [NUM_USED-1:0] loc_we,
  output logic [NUM_CH-1:0]   dyn_hit,
  output logic                test_hit
);

  always_comb begin
    loc_we = '0;
    for (int i = 0; i < NUM_USED; i++) begin
      if (wr_en && (int'(wr_addr) == i)) loc_we[i] = 1'b1;
    end
  end

  assign test_hit = wr_en && (int'(wr_addr) >= NUM_USED);

  for (genvar c = 0; c < NUM_CH; c++) begin : g_dyn
    assign dyn_hit[c] = loc_we[c*LOCS_PER_CH + LOCS_PER_CH - 1];
  end

  // R2: at most one location strobed per cycle, never together with a test hit
  assert_one_target_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({loc_we, test_hit}));

  // R6: a strobed protected address reaches no location
  assert_test_no_we_R6: assert property (@(posedge clk) disable iff (!rst_n)
    test_hit |-> (loc_we == '0));

endmodule

// File: rtl/cfgl_lock.sv
module cfgl_lock #(
  parameter int NUM_CH = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [NUM_CH-1:0] dyn_hit,
  output logic [NUM_CH-1:0] locked
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) locked <= '0;
    else        locked <= locked | dyn_hit;
  end

  for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
    // R4: a seal only appears after that channel's dynamic write
    assert_seal_cause_R4: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(locked[c]) |-> $past(dyn_hit[c]));
    // R5: a seal stays set until reset
    assert_seal_sticky_R5: assert property (@(posedge clk) disable iff (!rst_n)
      locked[c] |=> locked[c]);
  end

endmodule

// File: rtl/cfgl_loc.sv
module cfgl_loc #(
  parameter int              DATA_W    = 8,
  parameter logic [DATA_W-1:0] RST_VAL = '0,
  parameter bit              IS_STATIC = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic              locked,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] q
);

  localparam logic GUARD = IS_STATIC;

  logic accept;
  assign accept = we & ~(GUARD & locked);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      q <= RST_VAL;
    else if (accept) q <= wr_data;
  end

  // R2/R3: an accepted write lands on the next cycle
  assert_take_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (we && !(IS_STATIC && locked)) |=> (q == $past(wr_data)));

  // R4: a sealed static location holds its value
  assert_sealed_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (IS_STATIC && locked && we) |=> $stable(q));

  // R2: no strobe, no change
  assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !we |=> $stable(q));

endmodule

// File: rtl/cfgl_bank.sv
module cfgl_bank #(
  parameter int ADDR_W      = 3,
  parameter int DATA_W      = 8,
  parameter int LOCS_PER_CH = 3,
  localparam int NUM_CH     = 2,
  localparam int NUM_USED   = NUM_CH * LOCS_PER_CH
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       wr_en,
  input  logic [ADDR_W-1:0]          wr_addr,
  input  logic [DATA_W-1:0]          wr_data,
  output logic [NUM_USED*DATA_W-1:0] cfg_words,
  output logic                       a_rx_video_en,
  output logic                       a_rx_bist_en,
  output logic                       a_rx_pll_pd,
  output logic [1:0]                 a_rx_oe,
  output logic [1:0]                 b_tx_oe,
  output logic                       b_tx_bist_en,
  output logic                       b_pab_rst,
  output logic [NUM_CH-1:0]          static_locked,
  output logic                       wr_err
);
  import cfgl_pkg::*;

  localparam int A_STAT = 0;
  localparam int A_DYN  = LOCS_PER_CH - 1;
  localparam int B_STAT = LOCS_PER_CH;
  localparam int B_DYN  = 2 * LOCS_PER_CH - 1;

  logic [NUM_USED-1:0] loc_we;
  logic [NUM_CH-1:0]   dyn_hit;
  logic                test_hit;
  logic [DATA_W-1:0]   q [NUM_USED];

  cfgl_decode #(.ADDR_W(ADDR_W), .NUM_CH(NUM_CH), .LOCS_PER_CH(LOCS_PER_CH)) u_dec (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .loc_we(loc_we), .dyn_hit(dyn_hit), .test_hit(test_hit)
  );

  cfgl_lock #(.NUM_CH(NUM_CH)) u_lock (
    .clk(clk), .rst_n(rst_n), .dyn_hit(dyn_hit), .locked(static_locked)
  );

  for (genvar i = 0; i < NUM_USED; i++) begin : g_loc
    localparam loc_kind_e KIND = kind_of(i, LOCS_PER_CH, NUM_USED);
    localparam int        CH   = chan_of(i, LOCS_PER_CH);
    cfgl_loc #(
      .DATA_W(DATA_W),
      .RST_VAL(DATA_W'(reset_of(KIND))),
      .IS_STATIC(KIND == LOC_STATIC)
    ) u_loc (
      .clk(clk), .rst_n(rst_n), .we(loc_we[i]), .locked(static_locked[CH]),
      .wr_data(wr_data), .q(q[i])
    );
    assign cfg_words[i*DATA_W +: DATA_W] = q[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) wr_err <= 1'b0;
    else        wr_err <= test_hit;
  end

  assign a_rx_video_en = (q[A_DYN][1:0] == RXM_VIDEO);
  assign a_rx_bist_en  = (q[A_DYN][1:0] == RXM_BIST);
  assign a_rx_pll_pd   = q[A_DYN][2];
  assign a_rx_oe       = q[A_STAT][1:0];
  assign b_tx_oe       = q[B_STAT][1:0];
  assign b_pab_rst     = q[B_DYN][0];
  assign b_tx_bist_en  = q[B_DYN][1];

  // R6: protected writes leave every location alone and raise the flag
  assert_test_ignored_R6: assert property (@(posedge clk) disable iff (!rst_n)
    test_hit |=> ($stable(cfg_words) && wr_err));

  // R6: the flag has no other cause
  assert_err_cause_R6: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |-> $past(test_hit));

  // R7: a video code written to channel A's dynamic latch shows next cycle
  assert_mode_video_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_we[A_DYN] && wr_data[1:0] == RXM_VIDEO) |=>
      (a_rx_video_en && !a_rx_bist_en));

  // R3: the dynamic latch of channel B takes writes even when sealed
  assert_dyn_open_R3: assert property (@(posedge clk) disable iff (!rst_n)
    loc_we[B_DYN] |=> ({b_tx_bist_en, b_pab_rst} == $past(wr_data[1:0])));

endmodule

// File: tb/cfgl_bank_tb.sv
module cfgl_bank_tb;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  wr_addr = '0;
  logic [7:0]  wr_data = '0;
  logic [47:0] cfg_words;
  logic        a_rx_video_en, a_rx_bist_en, a_rx_pll_pd, b_tx_bist_en, b_pab_rst;
  logic [1:0]  a_rx_oe, b_tx_oe, static_locked;
  logic        wr_err;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [7:0] exp_q [6];
  bit         exp_lock [2];
  bit         exp_err;

  always #5 clk = ~clk;

  cfgl_bank u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cfg_words(cfg_words), .a_rx_video_en(a_rx_video_en), .a_rx_bist_en(a_rx_bist_en),
    .a_rx_pll_pd(a_rx_pll_pd), .a_rx_oe(a_rx_oe), .b_tx_oe(b_tx_oe),
    .b_tx_bist_en(b_tx_bist_en), .b_pab_rst(b_pab_rst),
    .static_locked(static_locked), .wr_err(wr_err)
  );

  task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < 6; i++) exp_q[i] = (i % 3 == 2) ? 8'h04 : 8'h00;
    exp_lock[0] = 0; exp_lock[1] = 0; exp_err = 0;
  endtask

  function automatic logic [47:0] packed_exp();
    logic [47:0] v;
    for (int i = 0; i < 6; i++) v[i*8 +: 8] = exp_q[i];
    return v;
  endfunction

  task automatic check_all(string tag);
    chk({tag, " words"}, 64'(cfg_words), 64'(packed_exp()));
    chk({tag, " R6 err"}, 64'(wr_err), 64'(exp_err));
    chk({tag, " R4 R5 seal"}, 64'(static_locked), 64'({exp_lock[1], exp_lock[0]}));
    chk({tag, " R7 mode"}, 64'({a_rx_video_en, a_rx_bist_en}),
        64'({exp_q[2][1:0] == 2'b01, exp_q[2][1:0] == 2'b10}));
    chk({tag, " R8 fields"}, 64'({a_rx_pll_pd, a_rx_oe, b_tx_oe, b_tx_bist_en, b_pab_rst}),
        64'({exp_q[2][2], exp_q[0][1:0], exp_q[3][1:0], exp_q[5][1], exp_q[5][0]}));
  endtask

  task automatic wr(int a, logic [7:0] d, string tag);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 3'(a); wr_data = d;
    exp_err = (a >= 6);
    if (a < 6) begin
      if (a % 3 == 2) begin
        exp_q[a] = d; exp_lock[a/3] = 1;
      end else if (!exp_lock[a/3]) begin
        exp_q[a] = d;
      end
    end
    @(negedge clk);
    wr_en = 1'b0;
    check_all(tag);
    if (exp_err) begin
      @(negedge clk);
      exp_err = 0;
      check_all("R6 pulse end");
    end
  endtask

  task automatic sweep_static(int p, string tag);
    for (int a = 0; a < 8; a++) begin
      if (a % 3 != 2 || a >= 6) wr(a, 8'((a * 37 + p * 91) ^ 8'hA5), tag);
    end
  endtask

  initial begin
    model_reset();
    repeat (3) @(negedge clk);
    check_all("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R1 after release");

    // strobe low with live address/data
    wr_addr = 3'd0; wr_data = 8'hFF;
    @(negedge clk);
    check_all("R2 strobe low");

    for (int p = 0; p < 3; p++) sweep_static(p, "R2 R4 open");

    wr(5, 8'h03, "R3 R5 seal B");
    for (int p = 3; p < 5; p++) sweep_static(p, "R4 R5 B sealed");

    for (int m = 0; m < 8; m++) wr(2, 8'(m), "R3 R7 R8 mode A");
    for (int p = 5; p < 7; p++) sweep_static(p, "R4 both sealed");
    wr(5, 8'h00, "R3 B dyn again");
    wr(5, 8'h02, "R3 R8 B bist");
    wr(7, 8'h00, "R6 test addr");

    @(negedge clk);
    rst_n = 1'b0;
    model_reset();
    @(negedge clk);
    check_all("R9 mid reset");
    rst_n = 1'b1;
    @(negedge clk);
    check_all("R9 after reset");
    wr(0, 8'h03, "R9 static open");
    wr(3, 8'h02, "R9 static open B");

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule